// File: doc/BRIEF.md
# Status flag bit unit

This unit executes the single-bit status instructions of an 8-bit microcontroller core. It holds the 8-bit status register and decodes 16-bit instruction words of four kinds:

- force one selected flag to one;
- force one selected flag to zero;
- copy the T flag into one bit of a general register;
- copy one bit of a general register into the T flag.

The flag index sits inside the opcode, so a single decoder covers all sixteen set and clear forms. The register file is outside the unit. The unit reaches it through one read port and one write port, and each port has an enable.

The instruction input is a plain valid-qualified stream with no ready signal. The unit accepts a valid word on every clock edge and never applies back-pressure, because every word it handles completes in one cycle. When `instr_valid` is low, the word is not consumed and has no effect. The register file read port is combinational: `rf_rd_data` must reflect `rf_rd_addr` within the same cycle. A register write happens on the same clock edge that retires the instruction.

Top module: `flagbit_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the status register to 8'h00.
- R2: The word 1001 0100 0sss 1000, presented with `instr_valid` high, sets status bit sss to one at the next clock edge. The other seven bits keep their values.
- R3: The word 1001 0100 1sss 1000, presented with `instr_valid` high, clears status bit sss to zero at the next clock edge. The other seven bits keep their values.
- R4: Status bit positions are: I=7, T=6, H=5, S=4, V=3, N=2, Z=1, C=0. The bit transfer instructions use bit 6 as T.
- R5: The word 1111 100d dddd 0bbb (register d = bits 8:4, bit b = bits 2:0) behaves as follows in the same cycle:
  - it raises `rf_rd_en` with `rf_rd_addr` = d;
  - it raises `rf_wr_en` with `rf_wr_addr` = d;
  - it drives `rf_wr_data` equal to the read value with bit b replaced by T.
  The status register is unchanged.
- R6: The word 1111 101d dddd xbbb raises `rf_rd_en` with `rf_rd_addr` = d and keeps `rf_wr_en` low. At the next edge, T takes bit b of the read value and all other flags hold. Bit 3 of the word is ignored.
- R7: A word matching none of the patterns above has these effects:
  - `recognised` is low;
  - both register file enables are low;
  - the status register is unchanged.
  This includes a bit-load word with bit 3 set.
- R8: `recognised` is high in the same cycle as a valid matching word. It is low whenever `instr_valid` is low, and a word presented then has no effect.
- R9: Set and clear words never enable either register file port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 16 | Instruction word |
| rf_rd_data | input | 8 | Register file read data (combinational) |
| rf_rd_en | output | 1 | Register file read enable |
| rf_rd_addr | output | 5 | Register file read index |
| rf_wr_en | output | 1 | Register file write enable |
| rf_wr_addr | output | 5 | Register file write index |
| rf_wr_data | output | 8 | Register file write data |
| flags | output | 8 | Status register contents |
| recognised | output | 1 | Word matched one of the handled patterns |

## Verification
The test first sets each flag in ascending order and then clears flags in a scattered order. A wrong bit index or a mask that disturbs neighbouring bits therefore shows up as a wrong full-byte value.

Bit loads run with T at one and then at zero, into registers holding both ones and zeros at the target bit. Bit stores then read the written bits back through T, once with the ignored bit 3 set. This separates insertion from extraction errors and catches a wrong register or bit field.

Near-miss words check the decoder's matching. These include a bit load with bit 3 set, a wrong low nibble and a wrong high byte. A matching word with `instr_valid` low is also tried.

// File: rtl/flagbit_pkg.sv
package flagbit_pkg;
  localparam int WORD_W = 16;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 5;
  localparam int BIDX_W = $clog2(DATA_W);
  localparam int T_POS  = 6;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_SETF,
    OP_CLRF,
    OP_TLOAD,
    OP_TSTORE
  } op_e;

  typedef struct packed {
    op_e               op;
    logic [ADDR_W-1:0] reg_idx;
    logic [BIDX_W-1:0] bit_idx;
  } dec_t;
endpackage

// File: rtl/flagbit_decode.sv
module flagbit_decode
  import flagbit_pkg::*;
(
  input  logic              valid,
  input  logic [WORD_W-1:0] word,
  output dec_t              dec
);
  always_comb begin
    dec.op      = OP_NONE;
    dec.reg_idx = word[8:4];
    dec.bit_idx = word[2:0];
    if (valid) begin
      if (word[15:8] == 8'h94 && word[3:0] == 4'h8) begin
        dec.op      = word[7] ? OP_CLRF : OP_SETF;
        dec.bit_idx = word[6:4];
      end else if (word[15:10] == 6'b111110) begin
        if (word[9]) begin
          dec.op = OP_TSTORE;
        end else if (!word[3]) begin
          dec.op = OP_TLOAD;
        end
      end
    end
  end
endmodule

// File: rtl/flagbit_bitmove.sv
module flagbit_bitmove
  import flagbit_pkg::*;
(
  input  logic [DATA_W-1:0] src,
  input  logic [BIDX_W-1:0] sel,
  input  logic              t_in,
  output logic [DATA_W-1:0] merged,
  output logic              picked
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign merged[i] = (sel == BIDX_W'(i)) ? t_in : src[i];
  end
  assign picked = src[sel];
endmodule

// File: rtl/flagbit_status.sv
module flagbit_status
  import flagbit_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  dec_t              dec,
  input  logic              t_new,
  output logic [DATA_W-1:0] status
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
    end else begin
      case (dec.op)
        OP_SETF:   status[dec.bit_idx] <= 1'b1;
        OP_CLRF:   status[dec.bit_idx] <= 1'b0;
        OP_TSTORE: status[T_POS]       <= t_new;
        default:   status              <= status;
      endcase
    end
  end
endmodule

// File: rtl/flagbit_unit.sv
module flagbit_unit
  import flagbit_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [WORD_W-1:0] instr_word,
  input  logic [DATA_W-1:0] rf_rd_data,
  output logic              rf_rd_en,
  output logic [ADDR_W-1:0] rf_rd_addr,
  output logic              rf_wr_en,
  output logic [ADDR_W-1:0] rf_wr_addr,
  output logic [DATA_W-1:0] rf_wr_data,
  output logic [DATA_W-1:0] flags,
  output logic              recognised
);
  dec_t dec;
  logic picked;

  flagbit_decode u_dec (
    .valid (instr_valid),
    .word  (instr_word),
    .dec   (dec)
  );

  flagbit_bitmove u_move (
    .src    (rf_rd_data),
    .sel    (dec.bit_idx),
    .t_in   (flags[T_POS]),
    .merged (rf_wr_data),
    .picked (picked)
  );

  flagbit_status u_stat (
    .clk    (clk),
    .rst    (rst),
    .dec    (dec),
    .t_new  (picked),
    .status (flags)
  );

  assign rf_rd_en   = (dec.op == OP_TLOAD) || (dec.op == OP_TSTORE);
  assign rf_rd_addr = dec.reg_idx;
  assign rf_wr_en   = (dec.op == OP_TLOAD);
  assign rf_wr_addr = dec.reg_idx;
  assign recognised = (dec.op != OP_NONE);
endmodule

// File: rtl/flagbit_unit_chk.sv
module flagbit_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        instr_valid,
  input logic [15:0] instr_word,
  input logic        rf_rd_en,
  input logic [4:0]  rf_rd_addr,
  input logic        rf_wr_en,
  input logic [4:0]  rf_wr_addr,
  input logic [7:0]  flags,
  input logic        recognised
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (flags == 8'h00));

  assert_single_flag_R2: assert property (@(posedge clk) disable iff (rst)
    (recognised && !rf_rd_en) |=> ($countones(flags ^ $past(flags)) <= 1));

  assert_write_same_reg_R5: assert property (@(posedge clk) disable iff (rst)
    rf_wr_en |-> (rf_rd_en && rf_wr_addr == rf_rd_addr));

  assert_load_keeps_flags_R5: assert property (@(posedge clk) disable iff (rst)
    rf_wr_en |=> $stable(flags));

  assert_store_only_t_R6: assert property (@(posedge clk) disable iff (rst)
    (rf_rd_en && !rf_wr_en) |=>
      (flags[5:0] == $past(flags[5:0]) && flags[7] == $past(flags[7])));

  assert_idle_no_enable_R7: assert property (@(posedge clk) disable iff (rst)
    !recognised |-> (!rf_rd_en && !rf_wr_en));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !recognised |=> $stable(flags));

  assert_invalid_unrecognised_R8: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |-> !recognised);

  assert_flag_op_no_rf_R9: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr_word[15:8] == 8'h94) |-> (!rf_rd_en && !rf_wr_en));
endmodule

bind flagbit_unit flagbit_unit_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .instr_valid (instr_valid),
  .instr_word  (instr_word),
  .rf_rd_en    (rf_rd_en),
  .rf_rd_addr  (rf_rd_addr),
  .rf_wr_en    (rf_wr_en),
  .rf_wr_addr  (rf_wr_addr),
  .flags       (flags),
  .recognised  (recognised)
);

// File: tb/tb_flagbit_unit.sv
module tb_flagbit_unit;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [15:0] instr_word = 16'h0000;
  logic [7:0]  rf_rd_data;
  logic        rf_rd_en;
  logic [4:0]  rf_rd_addr;
  logic        rf_wr_en;
  logic [4:0]  rf_wr_addr;
  logic [7:0]  rf_wr_data;
  logic [7:0]  flags;
  logic        recognised;

  always #(CLK_P/2) clk = ~clk;

  flagbit_unit dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .rf_rd_data(rf_rd_data), .rf_rd_en(rf_rd_en), .rf_rd_addr(rf_rd_addr),
    .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data),
    .flags(flags), .recognised(recognised)
  );

  // Bench register file: combinational read, write on the clock edge
  logic [7:0] rf_mem [32];
  logic [7:0] mdl_rf [32];
  logic [7:0] mdl_flags;
  assign rf_rd_data = rf_mem[rf_rd_addr];
  always @(posedge clk) if (rf_wr_en) rf_mem[rf_wr_addr] <= rf_wr_data;

  typedef struct {
    logic       rec;
    logic       rd_en;
    logic       wr_en;
    logic [4:0] addr;
    logic [7:0] wdata;
    logic [7:0] flags_after;
    string      req;
  } item_t;

  item_t exp_q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] w_set(input int s);
    return 16'h9408 | 16'(s << 4);
  endfunction
  function automatic logic [15:0] w_clr(input int s);
    return 16'h9488 | 16'(s << 4);
  endfunction
  function automatic logic [15:0] w_bld(input int d, input int b);
    return 16'hF800 | 16'(d << 4) | 16'(b);
  endfunction
  function automatic logic [15:0] w_bst(input int d, input int b, input int x);
    return 16'hFA00 | 16'(d << 4) | 16'(x << 3) | 16'(b);
  endfunction

  // Driver: presents one word and pushes the expected outcome
  task automatic issue(input logic [15:0] word, input logic valid, input string req);
    item_t it;
    logic [4:0] a;
    logic [2:0] b;
    @(negedge clk);
    instr_word  = word;
    instr_valid = valid;
    a = word[8:4];
    b = word[2:0];
    it.rec = 0; it.rd_en = 0; it.wr_en = 0; it.addr = a; it.wdata = 8'h00;
    it.flags_after = mdl_flags; it.req = req;
    if (valid) begin
      if (word[15:8] == 8'h94 && word[3:0] == 4'h8) begin
        it.rec = 1;
        it.flags_after[word[6:4]] = ~word[7];
      end else if (word[15:9] == 7'h7C && !word[3]) begin
        it.rec = 1; it.rd_en = 1; it.wr_en = 1;
        it.wdata = mdl_rf[a];
        it.wdata[b] = mdl_flags[6];
        mdl_rf[a] = it.wdata;
      end else if (word[15:9] == 7'h7D) begin
        it.rec = 1; it.rd_en = 1;
        it.flags_after[6] = mdl_rf[a][b];
      end
    end
    mdl_flags = it.flags_after;
    exp_q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  // Monitor: pops expectations and compares outputs
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (exp_q.size() > 0) begin
        it = exp_q.pop_front();
        chk(recognised == it.rec, {it.req, " recognised"}, recognised, it.rec);
        chk(rf_rd_en == it.rd_en, {it.req, " rd_en"}, rf_rd_en, it.rd_en);
        chk(rf_wr_en == it.wr_en, {it.req, " wr_en"}, rf_wr_en, it.wr_en);
        if (it.rd_en) chk(rf_rd_addr == it.addr, {it.req, " rd_addr"}, rf_rd_addr, it.addr);
        if (it.wr_en) begin
          chk(rf_wr_addr == it.addr, {it.req, " wr_addr"}, rf_wr_addr, it.addr);
          chk(rf_wr_data == it.wdata, {it.req, " wr_data"}, rf_wr_data, it.wdata);
        end
        @(posedge clk);
        #1;
        chk(flags == it.flags_after, {it.req, " flags"}, flags, it.flags_after);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      rf_mem[i] = 8'((i * 37 + 5) ^ 8'hA6);
      mdl_rf[i] = rf_mem[i];
    end
    mdl_flags = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(flags == 8'h00, "R1 reset flags", flags, 0);
    chk(recognised == 1'b0, "R8 reset recognised", recognised, 0);

    // R2/R4: set each flag in ascending order; T alone checked after s=6
    for (int s = 0; s < 8; s++) issue(w_set(s), 1'b1, "R2 set");
    issue(w_set(3), 1'b1, "R2 set already set");
    for (int s = 0; s < 8; s++) issue(w_clr(s), 1'b1, "R3 clear");
    issue(w_set(6), 1'b1, "R4 T at bit 6");
    idle();
    #(CLK_P/2);
    chk(flags == 8'h40, "R4 T position", flags, 8'h40);

    // R3: scattered clears from all-ones
    for (int s = 0; s < 8; s++) issue(w_set(s), 1'b1, "R2 set");
    issue(w_clr(5), 1'b1, "R3 clear H");
    issue(w_clr(0), 1'b1, "R3 clear C");
    issue(w_clr(7), 1'b1, "R3 clear I");
    issue(w_clr(2), 1'b1, "R3 clear N");
    issue(w_clr(2), 1'b1, "R3 clear cleared");

    // R5: bit load with T=1 then T=0
    issue(w_bld(4, 0), 1'b1, "R5 load T1");
    issue(w_bld(31, 7), 1'b1, "R5 load T1");
    issue(w_bld(17, 3), 1'b1, "R5 load T1");
    issue(w_clr(6), 1'b1, "R3 clear T");
    issue(w_bld(4, 2), 1'b1, "R5 load T0");
    issue(w_bld(0, 5), 1'b1, "R5 load T0");
    issue(w_bld(31, 7), 1'b1, "R5 load T0");

    // R6: bit store reads back, bit 3 ignored
    issue(w_bst(4, 0, 0), 1'b1, "R6 store");
    issue(w_bst(4, 2, 1), 1'b1, "R6 store x=1");
    issue(w_bst(17, 3, 0), 1'b1, "R6 store");
    issue(w_bst(31, 7, 1), 1'b1, "R6 store x=1");
    issue(w_bst(9, 6, 0), 1'b1, "R6 store");
    issue(w_bst(22, 1, 1), 1'b1, "R6 store x=1");

    // R7/R8/R9: near misses and invalid words
    issue(16'hF80B, 1'b1, "R7 load bit3 set");
    issue(16'h9409, 1'b1, "R7 low nibble");
    issue(16'h9508, 1'b1, "R7 high byte");
    issue(16'h0000, 1'b1, "R7 zero word");
    issue(16'hFC00, 1'b1, "R7 near transfer");
    issue(w_set(1), 1'b0, "R8 invalid set");
    issue(w_bld(3, 3), 1'b0, "R8 invalid load");
    issue(w_set(1), 1'b1, "R9 set no rf");

    idle();
    repeat (2) @(negedge clk);
    for (int i = 0; i < 32; i++)
      chk(rf_mem[i] == mdl_rf[i], "R5 register contents", rf_mem[i], mdl_rf[i]);

    // R1: reset in mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    mdl_flags = 8'h00;
    #1;
    chk(flags == 8'h00, "R1 mid-run reset", flags, 0);
    issue(w_set(7), 1'b1, "R2 set after reset");
    idle();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule